// File: doc/BRIEF.md
# Sequential Code Entry Checker

This block checks a run of button presses against a stored list of expected buttons. Each entry in the list is one step of a code. A press that matches the entry for the current step moves the block one step forward. A press that does not match sends it back to the first step and raises a one-cycle error pulse. When every step has been answered correctly in a row, the block opens. A higher layer uses the open state to show the final code.

The list of expected buttons is written in one cycle through a load strobe. Loading a list also restarts progress and closes the block. While the block is open it takes no further presses. Only reset or a new load brings it back into play. The current step index is visible at all times, so a display can show the prompt for that step.

Top module: `seqCodeChecker`

## Requirements
- R1: After reset, stepIdx is 0, isOpen is 0 and errPulse is 0, and every entry of the expected list is 0.
- R2: A cycle with loadValid high stores the list. Entry k is loadTable[4k+3:4k], and entry 0 is the first step. From the next cycle on, stepIdx is 0, isOpen is 0 and errPulse is 0.
- R3: When a press and a load occur in the same cycle, the load wins and the press has no effect.
- R4: A press whose pressId equals the entry for step k, with k below 4 and the block closed, gives stepIdx k+1 in the next cycle, with errPulse 0.
- R5: A matching press at step 4 sets isOpen in the next cycle. stepIdx stays at 4.
- R6: A press that does not match the current entry, with the block closed, gives stepIdx 0 in the next cycle.
- R7: errPulse is high in the cycle after each wrong press and low in every other cycle.
- R8: While isOpen is high, presses change neither stepIdx nor isOpen, and they raise no errPulse.
- R9: With no press and no load, stepIdx and isOpen hold their values.
- R10: stepIdx never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| pressValid | input | 1 | A button press is present this cycle |
| pressId | input | 4 | ID of the pressed button |
| loadValid | input | 1 | Write the expected-button list this cycle |
| loadTable | input | 20 | Expected list; entry k is in bits [4k+3:4k] |
| stepIdx | output | 3 | Index of the step now expected (0 to 4) |
| isOpen | output | 1 | All steps have been answered correctly |
| errPulse | output | 1 | One-cycle pulse after a wrong press |

## Verification
Every result appears one clock after the press or load that causes it, because stepIdx, isOpen and errPulse all come straight from registers. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It samples 1 ns after that edge to catch the new step index, open flag or error pulse. It then samples one period later to confirm that the error pulse has dropped and that the state holds with no stimulus.

// File: rtl/seqCodePkg.sv
package seqCodePkg;
  parameter int NUM_STEPS_DEF = 5;
  parameter int ID_W_DEF      = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;  // move to next step
    logic restart;  // go back to step 0
  } ctrlStrobeT;
endpackage

// File: rtl/seqCodeDatapath.sv
module seqCodeDatapath
  import seqCodePkg::*;
#(
  parameter int NUM_STEPS = NUM_STEPS_DEF,
  parameter int ID_W      = ID_W_DEF,
  localparam int IDX_W    = $clog2(NUM_STEPS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      loadValid,
  input  logic [NUM_STEPS*ID_W-1:0] loadTable,
  input  logic [ID_W-1:0]           pressId,
  input  ctrlStrobeT                strobe,
  output logic                      hit,
  output logic                      atLast,
  output logic [IDX_W-1:0]          stepIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

  logic [ID_W-1:0] expTable [NUM_STEPS];
  logic [ID_W-1:0] expId;

  for (genvar k = 0; k < NUM_STEPS; k++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          expTable[k] <= '0;
      else if (loadValid) expTable[k] <= loadTable[k*ID_W +: ID_W];
    end
  end

  always_comb begin
    expId = '0;
    for (int k = 0; k < NUM_STEPS; k++) begin
      if (stepIdx == IDX_W'(k)) expId = expTable[k];
    end
  end

  assign hit    = (pressId == expId);
  assign atLast = (stepIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stepIdx <= '0;
    else if (strobe.restart) stepIdx <= '0;
    else if (strobe.advance) stepIdx <= stepIdx + 1'b1;
  end
endmodule

// File: rtl/seqCodeCtrl.sv
module seqCodeCtrl
  import seqCodePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pressValid,
  input  logic       loadValid,
  input  logic       hit,
  input  logic       atLast,
  output ctrlStrobeT strobe,
  output logic       isOpen,
  output logic       errPulse
);
  logic accept;
  logic wrong;

  // presses only count while closed and when no load is present
  assign accept = pressValid && !isOpen && !loadValid;
  assign wrong  = accept && !hit;

  always_comb begin
    strobe.restart = loadValid || wrong;
    strobe.advance = accept && hit && !atLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isOpen   <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      errPulse <= wrong;
      if (loadValid)                   isOpen <= 1'b0;
      else if (accept && hit && atLast) isOpen <= 1'b1;
    end
  end
endmodule

// File: rtl/seqCodeChecker.sv
module seqCodeChecker
  import seqCodePkg::*;
#(
  parameter int NUM_STEPS = NUM_STEPS_DEF,
  parameter int ID_W      = ID_W_DEF,
  localparam int IDX_W    = $clog2(NUM_STEPS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      pressValid,
  input  logic [ID_W-1:0]           pressId,
  input  logic                      loadValid,
  input  logic [NUM_STEPS*ID_W-1:0] loadTable,
  output logic [IDX_W-1:0]          stepIdx,
  output logic                      isOpen,
  output logic                      errPulse
);
  ctrlStrobeT strobe;
  logic       hit;
  logic       atLast;

  seqCodeDatapath #(.NUM_STEPS(NUM_STEPS), .ID_W(ID_W)) uDp (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadTable(loadTable),
    .pressId(pressId), .strobe(strobe), .hit(hit), .atLast(atLast),
    .stepIdx(stepIdx)
  );

  seqCodeCtrl uCtrl (
    .clk(clk), .rstN(rstN), .pressValid(pressValid), .loadValid(loadValid),
    .hit(hit), .atLast(atLast), .strobe(strobe), .isOpen(isOpen),
    .errPulse(errPulse)
  );
endmodule

// File: rtl/seqCodeAssert.sv
module seqCodeAssert #(
  parameter int NUM_STEPS = 5,
  parameter int IDX_W     = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             pressValid,
  input logic             loadValid,
  input logic [IDX_W-1:0] stepIdx,
  input logic             isOpen,
  input logic             errPulse
);
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> (stepIdx == '0 && !isOpen && !errPulse));

  assert_open_on_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> ($past(pressValid) && stepIdx == IDX_W'(NUM_STEPS - 1)));

  assert_err_restarts_R6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (stepIdx == '0 && !isOpen));

  assert_err_needs_press_R7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> ($past(pressValid) && !$past(loadValid) && !$past(isOpen)));

  assert_open_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (isOpen && !loadValid) |=> (isOpen && $stable(stepIdx) && !errPulse));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!pressValid && !loadValid) |=> ($stable(stepIdx) && $stable(isOpen)));

  assert_step_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= IDX_W'(NUM_STEPS - 1));
endmodule

bind seqCodeChecker seqCodeAssert #(.NUM_STEPS(NUM_STEPS), .IDX_W(IDX_W)) uAssert (
  .clk(clk), .rstN(rstN), .pressValid(pressValid), .loadValid(loadValid),
  .stepIdx(stepIdx), .isOpen(isOpen), .errPulse(errPulse)
);

// File: tb/tb_seqCodeChecker.sv
`timescale 1ns/1ps
module tb_seqCodeChecker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pressValid = 1'b0;
  logic [3:0]  pressId = '0;
  logic        loadValid = 1'b0;
  logic [19:0] loadTable = '0;
  logic [2:0]  stepIdx;
  logic        isOpen;
  logic        errPulse;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  seqCodeChecker dut (
    .clk(clk), .rstN(rstN), .pressValid(pressValid), .pressId(pressId),
    .loadValid(loadValid), .loadTable(loadTable), .stepIdx(stepIdx),
    .isOpen(isOpen), .errPulse(errPulse)
  );

  logic [3:0] codeA [5] = '{4'd7, 4'd0, 4'd12, 4'd3, 4'd9};
  logic [3:0] codeB [5] = '{4'd15, 4'd15, 4'd1, 4'd8, 4'd2};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag, input int eStep, input int eOpen, input int eErr);
    check(stepIdx == eStep, {tag, " stepIdx"}, stepIdx, eStep);
    check(isOpen == eOpen, {tag, " isOpen"}, isOpen, eOpen);
    check(errPulse == eErr, {tag, " errPulse"}, errPulse, eErr);
  endtask

  // one-cycle press; returns 1 ns after the capturing edge
  task automatic doPress(input logic [3:0] id);
    @(negedge clk);
    pressValid = 1'b1;
    pressId = id;
    @(posedge clk);
    #1;
    pressValid = 1'b0;
  endtask

  task automatic doLoad(input logic [3:0] c [5], input bit withPress, input logic [3:0] id);
    @(negedge clk);
    loadValid = 1'b1;
    for (int k = 0; k < 5; k++) loadTable[k*4 +: 4] = c[k];
    pressValid = withPress;
    pressId = id;
    @(posedge clk);
    #1;
    loadValid = 1'b0;
    pressValid = 1'b0;
  endtask

  task automatic idleCycle();
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    checkState("R1 reset", 0, 0, 0);
    // R1: list is all zero, so button 0 matches step 0
    doPress(4'd0);
    checkState("R1 zero list", 1, 0, 0);
  endtask

  task automatic testFullRun(input logic [3:0] c [5], input string name);
    doLoad(c, 1'b0, 4'd0);
    checkState({"R2 load ", name}, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      doPress(c[k]);
      checkState({"R4 advance ", name}, k + 1, 0, 0);
    end
    doPress(c[4]);
    checkState({"R5 open ", name}, 4, 1, 0);
  endtask

  task automatic testOpenIgnore();
    doPress(codeA[0] ^ 4'd1);
    checkState("R8 wrong while open", 4, 1, 0);
    doPress(codeA[4]);
    checkState("R8 right while open", 4, 1, 0);
    idleCycle();
    checkState("R9 open holds", 4, 1, 0);
  endtask

  task automatic testWrongMid();
    doLoad(codeA, 1'b0, 4'd0);
    doPress(codeA[0]);
    doPress(codeA[1]);
    checkState("R4 at step 2", 2, 0, 0);
    doPress(4'd5);
    checkState("R6 R7 wrong mid", 0, 0, 1);
    idleCycle();
    checkState("R7 pulse ends R9 hold", 0, 0, 0);
    doPress(codeA[0]);
    checkState("R4 restart ok", 1, 0, 0);
  endtask

  task automatic testWrongLastAndBackToBack();
    for (int k = 1; k < 4; k++) doPress(codeA[k]);
    checkState("R4 at step 4", 4, 0, 0);
    doPress(4'd1);
    checkState("R6 wrong at last", 0, 0, 1);
    doPress(4'd2);
    checkState("R7 second wrong", 0, 0, 1);
    idleCycle();
    checkState("R7 drop", 0, 0, 0);
  endtask

  task automatic testLoadWins();
    doPress(codeA[0]);
    doPress(codeA[1]);
    // load with a press that matches codeB[0]: press must not count
    doLoad(codeB, 1'b1, codeB[0]);
    checkState("R3 load beats press", 0, 0, 0);
    // load with a wrong press: no error either
    doLoad(codeB, 1'b1, 4'd4);
    checkState("R3 no error on load", 0, 0, 0);
  endtask

  task automatic testReloadWhileOpen();
    testFullRun(codeB, "B");
    doLoad(codeA, 1'b0, 4'd0);
    checkState("R2 reload clears open", 0, 0, 0);
    doPress(codeB[0]);
    checkState("R2 new list in use", 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    testReset();
    testFullRun(codeA, "A");
    testOpenIgnore();
    testWrongMid();
    testWrongLastAndBackToBack();
    testLoadWins();
    testReloadWhileOpen();
    check(stepIdx <= 3'd4, "R10 range", stepIdx, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule